// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable model of a synchronous burst memory whose words are 36 bits wide, split into four 9-bit byte lanes. All address, data, enable and write-control inputs are sampled on the rising clock edge. An access sequence can be opened by either of two active-low start strobes.

The processor-side strobe always opens a read, and it is honoured only while the first chip enable is low. The controller-side strobe opens a read or a write, chosen by the write controls. Once a sequence is open, a 2-bit burst counter supplies the two low address bits. An advance input either steps that counter or holds it for a wait cycle. A static order input picks a linear or an interleaved sequence.

Read data is registered once and driven when the asynchronous output enable is active. A sleep input freezes the block and blanks the output at once. The top-level reset is asserted asynchronously and released through a two-stage synchronizer, so the core comes out of reset two clock edges after `rst_n` rises.

Top module: `burst_sram_core`

## Requirements
- R1: After reset, `dq_drive_o` is low, `rdata_o` is zero, and no sequence is open, so advance edges alone perform no access.
- R2: When `cpu_start_n`, `sel_a_n` and `sel_c_n` are low and `sel_b` is high at an edge, the block loads `addr_i` and reads that word. The word is on `rdata_o` right after that same edge.
- R3: `cpu_start_n` is ignored while `sel_a_n` is high. When it is accepted, it takes precedence over `ctl_start_n` and always reads, writing nothing even with the write controls asserted.
- R4: When `ctl_start_n` is low under the full enable, the block loads `addr_i`. If `write_all_n` is low, all 36 bits of `wdata_i` are written at that address on that edge, whatever the lane controls are.
- R5: With `write_all_n` high and `lane_wr_en_n` low, lane i (bits 9i+8 down to 9i of the word) is written only if `lane_wr_n[i]` is low. The other lanes keep their contents.
- R6: An access is a read only when `write_all_n` and `lane_wr_en_n` are both high. After a write cycle, `dq_drive_o` is low.
- R7: While a sequence is open, `advance_n` low steps the burst count by one, modulo 4. `advance_n` high holds the address and repeats the access. Each continuation edge reads or writes according to the write controls present at that edge.
- R8: With `order_sel` low, the two low address bits equal the starting low bits plus the count, modulo 4. The upper address bits stay fixed.
- R9: With `order_sel` high, the two low address bits equal the starting low bits XOR the count.
- R10: A start with any chip enable inactive (`sel_a_n` high, `sel_b` low or `sel_c_n` high) closes the sequence. No read or write then happens until the next accepted start, and `dq_drive_o` is low.
- R11: `out_en_n` high forces `dq_drive_o` low and `rdata_o` to zero at once, with no clock edge needed. Lowering it again restores the held data.
- R12: `sleep_i` high blanks the output at once. Edges during sleep change no state and write nothing. After release, the sequence resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Word address, loaded on an accepted start |
| cpu_start_n | input | 1 | Processor-side start strobe, active low, read only |
| ctl_start_n | input | 1 | Controller-side start strobe, active low |
| advance_n | input | 1 | Active-low burst step; high means wait cycle |
| sel_a_n | input | 1 | First chip enable, active low; also gates `cpu_start_n` |
| sel_b | input | 1 | Second chip enable, active high |
| sel_c_n | input | 1 | Third chip enable, active low |
| write_all_n | input | 1 | Active-low write of every lane |
| lane_wr_en_n | input | 1 | Active-low enable for the per-lane write lines |
| lane_wr_n | input | LANES | Active-low per-lane write lines, bit i for lane i |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_i | input | 1 | Active-high standby; freezes the block |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data; zero when not driving |
| dq_drive_o | output | 1 | High while `rdata_o` carries valid read data |

## Verification
The hardest case to reach from the ports is a sleep request that arrives in the middle of an open burst while the write controls are asserted. The block must then hold its count, write nothing and afterwards continue the sequence from the held address. The stimulus opens a read burst, steps it once, and raises sleep for two edges with `write_all_n` and `advance_n` both low. It then releases sleep, finishes the burst, and reads the same block again to show that no word changed. A similar sequence opens a deselecting start, then drives advance and write edges into the closed sequence, and reads back the untouched words afterwards.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int unsigned BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;
endpackage

// File: rtl/bsram_lane_dec.sv
module bsram_lane_dec #(
  parameter int unsigned LANES = 4
) (
  input  logic             write_all_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] lane_mask_o,
  output logic             wr_intent_o
);
  // the global write overrides the lane enable and every lane line
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask_o[g] = ~write_all_n | (~lane_wr_en_n & ~lane_wr_n[g]);
  end

  assign wr_intent_o = ~write_all_n | ~lane_wr_en_n;
endmodule

// File: rtl/bsram_burst_ord.sv
module bsram_burst_ord
  import bsram_pkg::*;
(
  input  logic [BURST_W-1:0] base_i,
  input  logic [BURST_W-1:0] cnt_i,
  input  logic               order_sel,
  output logic [BURST_W-1:0] low_o
);
  logic [BURST_W-1:0] lin_low;
  logic [BURST_W-1:0] ilv_low;

  assign lin_low = base_i + cnt_i;   // wraps inside the aligned block
  assign ilv_low = base_i ^ cnt_i;
  assign low_o   = order_sel ? ilv_low : lin_low;
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_start_n,
  input  logic                  ctl_start_n,
  input  logic                  advance_n,
  input  logic                  sel_a_n,
  input  logic                  chip_on,
  input  logic                  hold_i,
  input  logic                  wr_intent,
  input  logic [ADDR_W-1:0]     addr_i,
  output acc_e                  acc_o,
  output logic [ADDR_W-BURST_W-1:0] hi_o,
  output logic [BURST_W-1:0]    base_o,
  output logic [BURST_W-1:0]    cnt_o,
  output logic                  active_q_o,
  output logic [BURST_W-1:0]    cnt_q_o
);
  localparam int unsigned HI_W = ADDR_W - BURST_W;

  logic               active_q, active_d;
  logic [HI_W-1:0]    hi_q, hi_d;
  logic [BURST_W-1:0] base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic               cpu_go;
  logic               any_start;

  assign cpu_go    = ~cpu_start_n & ~sel_a_n;
  assign any_start = cpu_go | ~ctl_start_n;

  always_comb begin
    active_d = active_q;
    hi_d     = hi_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    acc_o    = ACC_IDLE;
    if (!hold_i) begin
      if (any_start) begin
        active_d = chip_on;
        hi_d     = addr_i[ADDR_W-1:BURST_W];
        base_d   = addr_i[BURST_W-1:0];
        cnt_d    = '0;
        if (chip_on) begin
          acc_o = (cpu_go || !wr_intent) ? ACC_RD : ACC_WR;
        end
      end else if (active_q) begin
        if (!advance_n) begin
          cnt_d = cnt_q + BURST_W'(1);
        end
        acc_o = wr_intent ? ACC_WR : ACC_RD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hi_q     <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (!hold_i) begin
      active_q <= active_d;
      hi_q     <= hi_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
    end
  end

  assign hi_o       = hi_d;
  assign base_o     = base_d;
  assign cnt_o      = cnt_d;
  assign active_q_o = active_q;
  assign cnt_q_o    = cnt_q;
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic                    rd_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_q,
  output logic                    rvalid_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (we_i[g]) begin
        mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (en_i && rd_i) begin
        lane_q <= mem[addr_i];
      end
    end

    assign rdata_q[g*LANE_W +: LANE_W] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else if (en_i) begin
      rvalid_q <= rd_i;
    end
  end
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    cpu_start_n,
  input  logic                    ctl_start_n,
  input  logic                    advance_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    write_all_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    order_sel,
  input  logic                    sleep_i,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    dq_drive_o
);
  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned HI_W   = ADDR_W - BURST_W;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  logic               chip_on;
  logic [LANES-1:0]   lane_mask;
  logic               wr_intent;
  acc_e               acc;
  logic [HI_W-1:0]    hi_nx;
  logic [BURST_W-1:0] base_nx;
  logic [BURST_W-1:0] cnt_nx;
  logic [BURST_W-1:0] low_nx;
  logic               active_q;
  logic [BURST_W-1:0] cnt_q;
  logic [ADDR_W-1:0]  acc_addr;
  logic [LANES-1:0]   lane_we;
  logic               rd_en;
  logic [DATA_W-1:0]  rdata_q;
  logic               rvalid_q;

  assign chip_on = ~sel_a_n & sel_b & ~sel_c_n;

  bsram_lane_dec #(.LANES(LANES)) u_lane (
    .write_all_n  (write_all_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_wr_n    (lane_wr_n),
    .lane_mask_o  (lane_mask),
    .wr_intent_o  (wr_intent)
  );

  bsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .advance_n   (advance_n),
    .sel_a_n     (sel_a_n),
    .chip_on     (chip_on),
    .hold_i      (sleep_i),
    .wr_intent   (wr_intent),
    .addr_i      (addr_i),
    .acc_o       (acc),
    .hi_o        (hi_nx),
    .base_o      (base_nx),
    .cnt_o       (cnt_nx),
    .active_q_o  (active_q),
    .cnt_q_o     (cnt_q)
  );

  bsram_burst_ord u_ord (
    .base_i    (base_nx),
    .cnt_i     (cnt_nx),
    .order_sel (order_sel),
    .low_o     (low_nx)
  );

  assign acc_addr = {hi_nx, low_nx};
  assign lane_we  = (acc == ACC_WR) ? lane_mask : '0;
  assign rd_en    = (acc == ACC_RD);

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en_i     (~sleep_i),
    .rd_i     (rd_en),
    .we_i     (lane_we),
    .addr_i   (acc_addr),
    .wdata_i  (wdata_i),
    .rdata_q  (rdata_q),
    .rvalid_q (rvalid_q)
  );

  assign dq_drive_o = rvalid_q & ~out_en_n & ~sleep_i;
  assign rdata_o    = dq_drive_o ? rdata_q : '0;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_start_n,
  input logic             ctl_start_n,
  input logic             advance_n,
  input logic             sel_a_n,
  input logic             chip_on,
  input logic             sleep_i,
  input logic             out_en_n,
  input logic             dq_drive,
  input logic [LANES-1:0] lane_we,
  input logic             rd_en,
  input logic             active_q,
  input logic [1:0]       cnt_q
);
  logic cpu_go;
  logic no_start;
  assign cpu_go   = ~cpu_start_n & ~sel_a_n;
  assign no_start = ctl_start_n & ~cpu_go;

  assert_cpu_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_go && chip_on && !sleep_i) |-> rd_en);

  assert_cpu_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_go && !sleep_i) |-> (lane_we == '0));

  assert_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !sleep_i && advance_n && no_start) |=> $stable(cnt_q));

  assert_step_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !sleep_i && !advance_n && no_start) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !chip_on && !no_start) |=> (!active_q && !dq_drive));

  assert_oe_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_drive);

  assert_sleep_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> (lane_we == '0 && !rd_en && !dq_drive));

  assert_sleep_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> ($stable(cnt_q) && $stable(active_q)));
endmodule

bind burst_sram_core bsram_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .cpu_start_n (cpu_start_n),
  .ctl_start_n (ctl_start_n),
  .advance_n   (advance_n),
  .sel_a_n     (sel_a_n),
  .chip_on     (chip_on),
  .sleep_i     (sleep_i),
  .out_en_n    (out_en_n),
  .dq_drive    (dq_drive_o),
  .lane_we     (lane_we),
  .rd_en       (rd_en),
  .active_q    (active_q),
  .cnt_q       (cnt_q)
);

// File: tb/burst_sram_core_tb.sv
`timescale 1ns/1ps
module burst_sram_core_tb;
  localparam int AW = 8;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          cpu_start_n, ctl_start_n, advance_n;
  logic          sel_a_n, sel_b, sel_c_n;
  logic          write_all_n, lane_wr_en_n;
  logic [3:0]    lane_wr_n;
  logic          order_sel, sleep_i, out_en_n;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic          dq_drive_o;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  burst_sram_core u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .advance_n(advance_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .write_all_n(write_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
    .order_sel(order_sel), .sleep_i(sleep_i), .out_en_n(out_en_n),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .dq_drive_o(dq_drive_o)
  );

  // behavioural reference state
  logic          m_act;
  logic [5:0]    m_hi;
  logic [1:0]    m_base, m_cnt;
  logic [DW-1:0] m_rd;
  logic          m_rv;
  logic [DW-1:0] mm [0:255];

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int kind = 0;
    logic cpu_ok, chipon, wr;
    logic [1:0] lo;
    logic [7:0] a;
    if (!sleep_i) begin
      cpu_ok = !cpu_start_n && !sel_a_n;
      chipon = !sel_a_n && sel_b && !sel_c_n;
      wr     = !write_all_n || !lane_wr_en_n;
      if (cpu_ok || !ctl_start_n) begin
        m_act = chipon; m_hi = addr_i[7:2]; m_base = addr_i[1:0]; m_cnt = 2'd0;
        if (chipon) kind = (cpu_ok || !wr) ? 1 : 2;
      end else if (m_act) begin
        if (!advance_n) m_cnt = m_cnt + 2'd1;
        kind = wr ? 2 : 1;
      end
      lo = order_sel ? (m_base ^ m_cnt) : (m_base + m_cnt);
      a  = {m_hi, lo};
      m_rv = (kind == 1);
      if (kind == 1) m_rd = mm[a];
      if (kind == 2) begin
        for (int l = 0; l < 4; l++)
          if (!write_all_n || !lane_wr_n[l]) mm[a][l*9 +: 9] = wdata_i[l*9 +: 9];
      end
    end
  endtask

  task automatic compare();
    logic ed;
    ed = m_rv && !out_en_n && !sleep_i;
    check(phase, {35'd0, dq_drive_o}, {35'd0, ed});
    check(phase, rdata_o, ed ? m_rd : '0);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    compare();
    @(negedge clk);
  endtask

  task automatic quiet();
    cpu_start_n = 1; ctl_start_n = 1; advance_n = 1;
    write_all_n = 1; lane_wr_en_n = 1; lane_wr_n = 4'hF;
  endtask

  // deliberately simple deterministic data mix
  function automatic logic [DW-1:0] pat(int k);
    return DW'(k * 64'h9E37_79B9) ^ {4{9'(k * 7 + 3)}};
  endfunction

  task automatic read_burst(logic [AW-1:0] a, bit use_cpu, int steps);
    quiet();
    addr_i = a;
    if (use_cpu) cpu_start_n = 0; else ctl_start_n = 0;
    tick();
    quiet();
    advance_n = 0;
    for (int s = 0; s < steps; s++) tick();
    quiet();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; addr_i = '0; wdata_i = '0;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0; order_sel = 0; sleep_i = 0; out_en_n = 0;
    quiet();
    m_act = 0; m_hi = '0; m_base = '0; m_cnt = '0; m_rd = '0; m_rv = 0;
    for (int i = 0; i < 256; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    phase = "R1";
    check("R1", {35'd0, dq_drive_o}, 36'd0);
    check("R1", rdata_o, '0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    advance_n = 0;           // R1: advance with no open sequence does nothing
    repeat (3) tick();
    quiet();

    // R4, R8: fill words 0..31 with global writes, linear bursts
    phase = "R4";
    for (int b = 0; b < 8; b++) begin
      quiet(); addr_i = AW'(b * 4); ctl_start_n = 0; write_all_n = 0;
      lane_wr_n = 4'b0101; wdata_i = pat(b * 4); tick();
      ctl_start_n = 1; advance_n = 0;
      for (int s = 1; s < 4; s++) begin wdata_i = pat(b * 4 + s); tick(); end
      quiet(); tick();
    end

    phase = "R2"; read_burst(8'd5, 1, 3);
    phase = "R8"; read_burst(8'd14, 0, 4);
    phase = "R9"; order_sel = 1; read_burst(8'd10, 1, 3);
    phase = "R9"; read_burst(8'd23, 0, 4);
    order_sel = 0;

    // R7: wait cycles inside a burst, then mixed write continuation
    phase = "R7";
    quiet(); addr_i = 8'd17; cpu_start_n = 0; tick();
    quiet(); tick(); tick();
    advance_n = 0; tick();
    advance_n = 1; tick();
    advance_n = 0; write_all_n = 0; wdata_i = pat(99); tick();
    quiet(); read_burst(8'd16, 0, 3);

    // R5: lane writes
    phase = "R5";
    quiet(); addr_i = 8'd13; ctl_start_n = 0; lane_wr_en_n = 0; lane_wr_n = 4'b1010;
    wdata_i = {4{9'h1A5}}; tick();
    ctl_start_n = 1; advance_n = 0; lane_wr_n = 4'b0111; wdata_i = {4{9'h0C3}}; tick();
    quiet(); read_burst(8'd13, 1, 2);

    // R6: write cycle leaves output idle, lane enable with no lane still writes nothing
    phase = "R6";
    quiet(); addr_i = 8'd20; ctl_start_n = 0; lane_wr_en_n = 0; lane_wr_n = 4'hF; tick();
    quiet(); read_burst(8'd20, 0, 1);

    // R3: ignored processor strobe, and precedence with writes asserted
    phase = "R3";
    quiet(); addr_i = 8'd24; ctl_start_n = 0; tick();
    quiet(); sel_a_n = 1; cpu_start_n = 0; advance_n = 0; addr_i = 8'd2; tick(); tick();
    sel_a_n = 0; quiet();
    addr_i = 8'd28; cpu_start_n = 0; ctl_start_n = 0; write_all_n = 0; wdata_i = pat(77); tick();
    quiet(); read_burst(8'd28, 0, 1);

    // R10: deselect, then advance and write into the closed sequence
    phase = "R10";
    quiet(); addr_i = 8'd8; sel_b = 0; ctl_start_n = 0; tick();
    sel_b = 1; quiet(); advance_n = 0; write_all_n = 0; wdata_i = pat(55); tick(); tick();
    quiet(); sel_c_n = 1; cpu_start_n = 0; addr_i = 8'd9; tick();
    sel_c_n = 0; quiet(); write_all_n = 0; tick();
    quiet(); read_burst(8'd8, 1, 3);

    // R11: asynchronous output enable
    phase = "R11";
    quiet(); addr_i = 8'd4; cpu_start_n = 0; tick();
    quiet(); out_en_n = 1; #1; compare();
    tick();
    out_en_n = 0; #1; compare();
    tick();

    // R12: sleep mid-burst with writes asserted
    phase = "R12";
    quiet(); addr_i = 8'd16; ctl_start_n = 0; tick();
    quiet(); advance_n = 0; tick();
    sleep_i = 1; write_all_n = 0; wdata_i = pat(123); #1; compare();
    tick(); tick();
    sleep_i = 0; quiet(); advance_n = 0; tick(); tick();
    quiet(); read_burst(8'd16, 1, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule